// File: doc/BRIEF.md
# Synchronous Serial Port with Master Contention Detection

A byte-wide synchronous serial port that always drives the serial clock. Software programs a control register, a clock divider and a data register over a small register bus. Writing the data register while the port is idle starts an eight-bit transfer. The byte shifts out most significant bit first while the same number of bits is shifted in from the receive pin. Two control bits pick one of four operating modes, and these decide which data pin transmits and which one receives. Two more bits set the idle level of the clock and the edge on which data is launched.

In the two channel-select modes the port also watches an active-low select input that other masters can pull. A falling edge on that input sets a contention pending flag. If the contention interrupt enable is set, the same edge also sets the port's single interrupt pending bit. That bit is shared with transfer completion. Software clears each flag by writing zero to it.

Register map, with the address on `bus_addr`: 0 is control, 1 is data (a write starts a transfer, a read returns the receive shifter), 2 is status, and 3 is the divider.

Top module: `ssp_port`

## Requirements
- R1: After reset, all four registers read 00h, `sclk` is low, both output enables are low, and `irq` and `con_flag` are low.
- R2: Control bits [7:6] always read zero. Writing 1 to control bit 5 (contention pending) never sets it, so writing FFh reads back 1Fh.
- R3: Control bits [1:0] select the mode. 00 transmits and receives on pin 0. 01 transmits on pin 0 and receives on pin 1. 10 transmits and receives on pin 1 only, with pin 0 undriven. 11 transmits on pin 0 and receives on pin 1. An output enable is high only while a transfer runs, and an undriven data output reads 0.
- R4: A transfer sends 8 bits MSB first over 8 serial clock periods. Each clock half-period lasts (divider + 1) system clocks. After the transfer, data register reads return the received byte, with the first received bit in bit 7.
- R5: Control bit 2 sets the idle level of `sclk`. With control bit 3 at 0, the first bit is on the pin before the first clock edge, input is sampled on leading edges and output changes on trailing edges. With bit 3 at 1, output changes on leading edges and input is sampled on trailing edges.
- R6: At the end of the eighth bit, status bit 0 (done) and status bit 1 (interrupt pending, which drives `irq`) are set. Writing 0 to either bit clears it, and writing 1 leaves it unchanged. Status bit 2 reads the busy state.
- R7: A data register write while a transfer is running is ignored and does not disturb the running transfer.
- R8: In modes 10 and 11, a falling edge on `chs_n` sets control bit 5 and `con_flag`, two system clocks after the input is first sampled low.
- R9: Control bit 4 sets the path for a contention event. At 0, only control bit 5 is set. At 1, status bit 1 is set as well.
- R10: In modes 00 and 01, `chs_n` and control bit 4 have no effect on control bit 5 or on `irq`.
- R11: Writing control bit 5 as 0 clears the contention flag. A contention event in the same cycle as that write wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| sclk | output | 1 | Serial clock |
| sd0_out | output | 1 | Data pin 0 output value |
| sd0_oe | output | 1 | Data pin 0 output enable |
| sd0_in | input | 1 | Data pin 0 input value |
| sd1_out | output | 1 | Data pin 1 output value |
| sd1_oe | output | 1 | Data pin 1 output enable |
| sd1_in | input | 1 | Data pin 1 input value |
| chs_n | input | 1 | Active-low channel-select input, asynchronous |
| irq | output | 1 | Serial-port interrupt pending |
| con_flag | output | 1 | Contention pending flag |

## Verification
The hardest case to reach from the ports is a software clear of the contention flag that lands on the same clock as a newly detected select edge. The detection comes out of a synchronizer, several cycles after the pin moves. The bench lowers `chs_n` on a chosen falling clock edge and places the control write exactly two edges later, so the write and the internal detection meet on one clock. A behavioural model that mirrors the requirements is compared with every output on every cycle. That model covers all sixteen mode, phase and polarity combinations, plus a loop-back transfer that receives its own transmit pin.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   typedef enum logic [1:0] {
      MODE_STD = 2'b00,
      MODE_DUP = 2'b01,
      MODE_CSH = 2'b10,
      MODE_CSF = 2'b11
   } ssp_mode_e;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_DATA = 2'd1;
   localparam logic [1:0] ADDR_STAT = 2'd2;
   localparam logic [1:0] ADDR_DIV  = 2'd3;

   localparam int BUS_W = 8;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_n,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad
         $error("ssp_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= async_n;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[STAGES-1];
   end

   assign fall = prev & ~chain[STAGES-1];

   assert_fall_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
   parameter int BITS  = 8,
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [BITS-1:0]  load,
   input  logic             cpha,
   input  logic [DIV_W-1:0] div,
   input  logic             rx_pin,
   output logic             busy,
   output logic             lvl,
   output logic             out_bit,
   output logic [BITS-1:0]  rx_byte,
   output logic             fin
);
   localparam int EDGES  = 2 * BITS;
   localparam int EDGE_W = $clog2(EDGES);
   localparam logic [EDGE_W-1:0] LAST = EDGE_W'(EDGES - 1);

   generate
      if (BITS < 2) begin : g_bad
         $error("ssp_shifter: BITS must be at least 2");
      end
   endgenerate

   logic [DIV_W-1:0]  div_cnt;
   logic [EDGE_W-1:0] edges;
   logic [BITS-1:0]   tx;
   logic              tick, lead, samp;

   assign tick = busy && (div_cnt == div);
   assign lead = ~edges[0];
   assign samp = lead ^ cpha;
   assign fin  = tick && (edges == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         lvl     <= 1'b0;
         out_bit <= 1'b0;
         div_cnt <= '0;
         edges   <= '0;
         tx      <= '0;
         rx_byte <= '0;
      end else if (busy) begin
         if (tick) begin
            lvl     <= ~lvl;
            edges   <= edges + 1'b1;
            div_cnt <= '0;
            if (samp) begin
               rx_byte <= {rx_byte[BITS-2:0], rx_pin};
            end else begin
               out_bit <= tx[BITS-1];
               tx      <= {tx[BITS-2:0], 1'b0};
            end
            if (edges == LAST) busy <= 1'b0;
         end else begin
            div_cnt <= div_cnt + 1'b1;
         end
      end else if (start) begin
         busy    <= 1'b1;
         lvl     <= 1'b0;
         div_cnt <= '0;
         edges   <= '0;
         if (cpha) begin
            out_bit <= 1'b0;
            tx      <= load;
         end else begin
            out_bit <= load[BITS-1];
            tx      <= {load[BITS-2:0], 1'b0};
         end
      end
   end

   assert_hold_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && div_cnt != div) |=> lvl == $past(lvl));
   assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !lvl);
   assert_fin_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !busy);
endmodule

// File: rtl/ssp_regs.sv
module ssp_regs
   import ssp_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       addr,
   input  logic             we,
   input  logic [BUS_W-1:0] wdata,
   input  logic             fall,
   input  logic             fin,
   input  logic             busy,
   input  logic [BUS_W-1:0] rx_byte,
   output logic [BUS_W-1:0] rdata,
   output ssp_mode_e        mode,
   output logic             cpol,
   output logic             cpha,
   output logic [DIV_W-1:0] div,
   output logic             start,
   output logic             irq,
   output logic             con_pend
);
   generate
      if (DIV_W < 1 || DIV_W > BUS_W) begin : g_bad
         $error("ssp_regs: DIV_W must be 1..8");
      end
   endgenerate

   logic con_ie, done;
   logic wr_ctrl, wr_stat, wr_div, con_set, irq_set;

   assign wr_ctrl = we && (addr == ADDR_CTRL);
   assign wr_stat = we && (addr == ADDR_STAT);
   assign wr_div  = we && (addr == ADDR_DIV);
   assign start   = we && (addr == ADDR_DATA) && !busy;
   assign con_set = fall && mode[1];
   assign irq_set = fin || (con_set && con_ie);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= MODE_STD;
         cpol     <= 1'b0;
         cpha     <= 1'b0;
         con_ie   <= 1'b0;
         con_pend <= 1'b0;
         done     <= 1'b0;
         irq      <= 1'b0;
         div      <= '0;
      end else begin
         if (wr_ctrl) begin
            mode     <= ssp_mode_e'(wdata[1:0]);
            cpol     <= wdata[2];
            cpha     <= wdata[3];
            con_ie   <= wdata[4];
            con_pend <= con_set | (con_pend & wdata[5]);
         end else begin
            con_pend <= con_pend | con_set;
         end
         if (wr_stat) begin
            done <= fin | (done & wdata[0]);
            irq  <= irq_set | (irq & wdata[1]);
         end else begin
            done <= done | fin;
            irq  <= irq | irq_set;
         end
         if (wr_div) div <= wdata[DIV_W-1:0];
      end
   end

   always_comb begin
      case (addr)
         ADDR_CTRL: rdata = {2'b00, con_pend, con_ie, cpha, cpol, mode};
         ADDR_DATA: rdata = rx_byte;
         ADDR_STAT: rdata = {5'b0, busy, irq, done};
         default:   rdata = BUS_W'(div);
      endcase
   end

   assert_con_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && mode[1]) |=> con_pend);
   assert_con_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !mode[1] && !wr_ctrl) |=> $stable(con_pend));
   assert_irq_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && mode[1] && !con_ie && !fin && !wr_stat) |=> irq == $past(irq));
endmodule

// File: rtl/ssp_port.sv
module ssp_port
   import ssp_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] bus_addr,
   input  logic       bus_we,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       sclk,
   output logic       sd0_out,
   output logic       sd0_oe,
   input  logic       sd0_in,
   output logic       sd1_out,
   output logic       sd1_oe,
   input  logic       sd1_in,
   input  logic       chs_n,
   output logic       irq,
   output logic       con_flag
);
   localparam int BITS = BUS_W;

   ssp_mode_e        mode;
   logic             cpol, cpha, start, fall, fin, busy, lvl, out_bit, rx_pin;
   logic [DIV_W-1:0] div;
   logic [BITS-1:0]  rx_byte;
   logic             tx_on_sd1, rx_on_sd0;

   ssp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_n(chs_n), .fall(fall));

   ssp_regs #(.DIV_W(DIV_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
      .fall(fall), .fin(fin), .busy(busy), .rx_byte(rx_byte), .rdata(bus_rdata),
      .mode(mode), .cpol(cpol), .cpha(cpha), .div(div), .start(start),
      .irq(irq), .con_pend(con_flag));

   ssp_shifter #(.BITS(BITS), .DIV_W(DIV_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .load(bus_wdata), .cpha(cpha),
      .div(div), .rx_pin(rx_pin), .busy(busy), .lvl(lvl), .out_bit(out_bit),
      .rx_byte(rx_byte), .fin(fin));

   assign tx_on_sd1 = (mode == MODE_CSH);
   assign rx_on_sd0 = (mode == MODE_STD);
   assign rx_pin    = rx_on_sd0 ? sd0_in : sd1_in;
   assign sd0_oe    = busy & ~tx_on_sd1;
   assign sd1_oe    = busy & tx_on_sd1;
   assign sd0_out   = sd0_oe & out_bit;
   assign sd1_out   = sd1_oe & out_bit;
   assign sclk      = lvl ^ cpol;

   assert_pin_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sd0_oe, sd1_oe}));
endmodule

// File: tb/ssp_port_bench.sv
module ssp_port_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       sclk, sd0_out, sd0_oe, sd1_out, sd1_oe, irq, con_flag;
   logic       sd0_in = 1'b0, sd1_in = 1'b0, chs_n = 1'b1;

   always #5 clk = ~clk;

   ssp_port u_ssp_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk),
      .sd0_out(sd0_out), .sd0_oe(sd0_oe), .sd0_in(sd0_in),
      .sd1_out(sd1_out), .sd1_oe(sd1_oe), .sd1_in(sd1_in),
      .chs_n(chs_n), .irq(irq), .con_flag(con_flag));

   int checks = 0, failures = 0;
   bit cmp_on = 1'b0, loop = 1'b0, ended = 1'b0;
   logic [7:0] lfsr = 8'h5B;
   int rises = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp,
                      input string what);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // reference model state
   logic [1:0] m_mode;
   logic       m_cpol, m_cpha, m_ie, m_con, m_done, m_irq, m_busy, m_lvl, m_out;
   int         m_div, m_cnt, m_edges;
   logic [7:0] m_tx, m_rx;
   int         chs_q[$];
   logic       m_det, m_fin, m_start, m_iset, m_rxpin, m_lead;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 2'b00; m_cpol = 0; m_cpha = 0; m_ie = 0; m_con = 0; m_done = 0;
         m_irq = 0; m_busy = 0; m_lvl = 0; m_out = 0; m_div = 0; m_cnt = 0;
         m_edges = 0; m_tx = 0; m_rx = 0;
         chs_q = '{1, 1, 1};
      end else begin
         m_det   = (chs_q[2] == 1) && (chs_q[1] == 0) && m_mode[1];
         m_fin   = 1'b0;
         m_start = bus_we && (bus_addr == 2'd1) && !m_busy;
         m_rxpin = (m_mode == 2'b00) ? sd0_in : sd1_in;
         if (m_busy) begin
            if (m_cnt == m_div) begin
               m_lead = (m_edges % 2) == 0;
               m_lvl  = !m_lvl;
               if (m_lead ^ m_cpha) m_rx = {m_rx[6:0], m_rxpin};
               else begin m_out = m_tx[7]; m_tx = m_tx << 1; end
               if (m_edges == 15) begin m_busy = 0; m_fin = 1; end
               m_edges++;
               m_cnt = 0;
            end else m_cnt++;
         end else if (m_start) begin
            m_busy = 1; m_cnt = 0; m_edges = 0; m_lvl = 0;
            if (m_cpha) begin m_out = 0; m_tx = bus_wdata; end
            else begin m_out = bus_wdata[7]; m_tx = {bus_wdata[6:0], 1'b0}; end
         end
         m_iset = m_fin || (m_det && m_ie);
         if (bus_we && bus_addr == 2'd0) begin
            m_mode = bus_wdata[1:0]; m_cpol = bus_wdata[2]; m_cpha = bus_wdata[3];
            m_ie = bus_wdata[4]; m_con = m_det | (m_con & bus_wdata[5]);
         end else m_con = m_con | m_det;
         if (bus_we && bus_addr == 2'd2) begin
            m_done = m_fin | (m_done & bus_wdata[0]);
            m_irq  = m_iset | (m_irq & bus_wdata[1]);
         end else begin
            m_done = m_done | m_fin;
            m_irq  = m_irq | m_iset;
         end
         if (bus_we && bus_addr == 2'd3) m_div = bus_wdata;
         chs_q.push_front(chs_n);
         void'(chs_q.pop_back());
      end
   end

   // per-cycle comparison, away from the clock edge and before inputs move
   always @(posedge clk) begin
      #4;
      if (rst_n && cmp_on) begin
         logic [7:0] exp_rd;
         logic       t1;
         t1 = (m_mode == 2'b10);
         case (bus_addr)
            2'd0:    exp_rd = {2'b00, m_con, m_ie, m_cpha, m_cpol, m_mode};
            2'd1:    exp_rd = m_rx;
            2'd2:    exp_rd = {5'b0, m_busy, m_irq, m_done};
            default: exp_rd = m_div[7:0];
         endcase
         chk(sclk == (m_lvl ^ m_cpol), "R5", sclk, m_lvl ^ m_cpol, "sclk");
         chk(sd0_oe == (m_busy & !t1), "R3", sd0_oe, m_busy & !t1, "sd0_oe");
         chk(sd1_oe == (m_busy & t1), "R3", sd1_oe, m_busy & t1, "sd1_oe");
         chk(sd0_out == (m_busy & !t1 & m_out), "R3", sd0_out, m_busy & !t1 & m_out, "sd0_out");
         chk(sd1_out == (m_busy & t1 & m_out), "R3", sd1_out, m_busy & t1 & m_out, "sd1_out");
         chk(irq == m_irq, "R6", irq, m_irq, "irq");
         chk(con_flag == m_con, "R8", con_flag, m_con, "con_flag");
         chk(bus_rdata == exp_rd, "R4", bus_rdata, exp_rd, "rdata");
      end
   end

   // data pin stimulus: loop-back or pseudo-random
   always @(negedge clk) begin
      if (loop) sd0_in <= sd0_out;
      else begin
         lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         sd0_in <= lfsr[0];
         sd1_in <= lfsr[3];
      end
   end

   always @(posedge sclk) rises++;

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      int n = 0;
      s = 8'hFF;
      while (s[2] && n < 2000) begin
         rd(2'd2, s);
         n++;
      end
   endtask

   task automatic pulse_chs();
      @(negedge clk); chs_n = 1'b0;
      repeat (4) @(negedge clk);
      chs_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL R4 watchdog actual=timeout expected=finish");
      summary();
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(sclk == 0 && sd0_oe == 0 && sd1_oe == 0, "R1", {sclk, sd0_oe, sd1_oe}, 0, "pins");
      chk(irq == 0 && con_flag == 0, "R1", {irq, con_flag}, 0, "flags");
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk(v == 8'h00, "R1", v, 0, "reg after reset");
      end
      cmp_on = 1'b1;

      // R2 reserved bits and pending bit not settable
      wr(2'd0, 8'hFF);
      rd(2'd0, v);
      chk(v == 8'h1F, "R2", v, 8'h1F, "ctrl readback");
      wr(2'd0, 8'h00);

      // R3/R4/R5/R6 all modes, polarities and phases
      wr(2'd3, 8'd1);
      for (int m = 0; m < 16; m++) begin
         wr(2'd0, 8'(m));
         wr(2'd1, 8'(8'h96 ^ (m * 8'h1D)));
         wait_idle();
         rd(2'd2, v);
         chk(v[1:0] == 2'b11 && irq == 1, "R6", {v[1:0], irq}, 3'b111, "done and irq");
         rd(2'd1, v);
         wr(2'd2, 8'h00);
         rd(2'd2, v);
         chk(v == 8'h00 && irq == 0, "R6", {v, irq}, 0, "status cleared");
      end

      // R7 ignored write during transfer, R4 loop-back and clock count
      loop = 1'b1;
      wr(2'd0, 8'h00);
      wr(2'd3, 8'd2);
      rises = 0;
      wr(2'd1, 8'hA5);
      wr(2'd1, 8'h3C);
      wait_idle();
      rd(2'd1, v);
      chk(v == 8'hA5, "R7", v, 8'hA5, "received byte after ignored write");
      chk(rises == 8, "R4", rises, 8, "serial clock periods");
      wr(2'd2, 8'h00);
      loop = 1'b0;

      // R8/R9 contention with enable off
      wr(2'd0, 8'h03);
      pulse_chs();
      chk(con_flag == 1, "R8", con_flag, 1, "contention flag");
      chk(irq == 0, "R9", irq, 0, "irq with enable off");
      rd(2'd0, v);
      chk(v[5] == 1, "R8", v[5], 1, "ctrl bit5");
      wr(2'd0, 8'h03);
      chk(con_flag == 0, "R11", con_flag, 0, "flag cleared");

      // R9 with enable on
      wr(2'd0, 8'h13);
      pulse_chs();
      rd(2'd2, v);
      chk(con_flag == 1 && v[1] == 1, "R9", {con_flag, v[1]}, 2'b11, "flag and irq pending");
      wr(2'd0, 8'h13);
      wr(2'd2, 8'h00);

      // R10 non channel-select modes
      wr(2'd0, 8'h11);
      pulse_chs();
      chk(con_flag == 0 && irq == 0, "R10", {con_flag, irq}, 0, "duplex mode");
      wr(2'd0, 8'h10);
      pulse_chs();
      chk(con_flag == 0 && irq == 0, "R10", {con_flag, irq}, 0, "standard mode");

      // R11 clear coinciding with detection
      wr(2'd0, 8'h02);
      @(negedge clk); chs_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      bus_addr = 2'd0; bus_wdata = 8'h02; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      chs_n = 1'b1;
      #1;
      chk(con_flag == 1, "R11", con_flag, 1, "set wins over clear");
      wr(2'd0, 8'h02);
      chk(con_flag == 0, "R11", con_flag, 0, "later clear");

      repeat (4) @(negedge clk);
      summary();
   end
endmodule